// File: doc/BRIEF.md
# Eight-Input Serializer with CRC Status

This block serializes eight digital levels out of the device end of an SPI link. When chip select falls, the block takes a snapshot of the filtered inputs. It then shifts that byte out most significant bit first. In the long frame format, a status byte follows the data byte. The status byte holds a five-bit CRC of the data byte and three supply and temperature health flags. A serial input lets several devices share one chain. Bits that enter on the serial input come out on the serial output right after the device's own frame, so a host can read a whole chain of devices in one transfer.

Each input has its own debounce filter. A two-bit select chooses one of four filter lengths, and every length is a parameter counted in system clock cycles. A fault output shows overtemperature or an undervoltage alarm. All SPI pins and level inputs are oversampled by the system clock through two-stage synchronizers. The serial clock must therefore run well below the system clock.

Top module: `serin8_crc_top`

## Requirements
- R1: After chip select falls, sdo_o carries data bit 7 first. Each falling sclk_i edge moves sdo_o to the next bit, and sdi_i is sampled on each rising sclk_i edge.
- R2: With wide_i=1 the frame is 16 bits: the data byte, then a status byte. Status bits [7:3] hold the CRC-5 of the data byte (polynomial x^5+x^4+x^2+1, zero start value, MSB first). Bit 2 is the inverse of uv_alarm_i, bit 1 equals ot_i, and bit 0 is the inverse of uv_warn_i.
- R3: With wide_i=0 the frame is the 8 data bits only.
- R4: Once its own frame has been shifted out, sdo_o repeats the sdi_i bits in the order they were received.
- R5: Data, health flags and frame mode are captured when chip select falls. Changing them while chip select stays low has no effect on the frame in progress.
- R6: sdo_o is 0 while cs_n_i is high.
- R7: With dbsel_i=00 a new input level reaches the next snapshot within 4 system clocks.
- R8: With dbsel_i = 01, 10 or 11 (short, medium, long: DB_SHORT, DB_MED, DB_LONG cycles), an input takes a new level only after it has stayed at that level for the selected count. Shorter pulses are ignored.
- R9: fault_o is high exactly when ot_i or uv_alarm_i was high, delayed by the synchronizer and one register stage (3 clocks).
- R10: After reset, sdo_o and fault_o are 0 and the filtered input byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock |
| cs_n_i | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | Chain serial input |
| din_i | input | 8 | Raw digital inputs |
| wide_i | input | 1 | 1 = data plus status frame, 0 = data only |
| ot_i | input | 1 | Overtemperature, high true |
| uv_alarm_i | input | 1 | Undervoltage alarm, high true |
| uv_warn_i | input | 1 | Undervoltage warning, high true |
| dbsel_i | input | 2 | Debounce select |
| sdo_o | output | 1 | SPI serial output |
| fault_o | output | 1 | Alarm or overtemperature present |

## Verification
The assertions assume that each sclk_i level lasts several system clocks, so that a synchronized rising edge and a falling edge never fall in the same cycle. They also assume that sdi_i is settled before the rising edge that samples it. The bench holds every SPI level for six clocks and changes sdi_i only at a falling sclk_i edge. It changes din_i and the health inputs only while chip select is high, except in the one test that checks they are ignored during a frame.

// File: rtl/serin8_pkg.sv
package serin8_pkg;

  localparam int unsigned DATA_W = 8;
  localparam logic [4:0]  CRC_TAPS = 5'h15;

  function automatic logic [4:0] crc5_of(input logic [DATA_W-1:0] d);
    logic [4:0] c;
    logic       fb;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ CRC_TAPS;
    end
    return c;
  endfunction

  function automatic logic [7:0] status_of(input logic [DATA_W-1:0] d,
                                           input logic ot, input logic uva,
                                           input logic uvw);
    return {crc5_of(d), ~uva, ot, ~uvw};
  endfunction

endpackage

// File: rtl/serin8_sync.sv
module serin8_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/serin8_dbnc_lane.sv
module serin8_dbnc_lane #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] lim,
  output logic          filt
);
  logic [CW-1:0] cnt;
  logic          bypass;
  logic          differs;
  logic          ripe;

  assign bypass  = (lim == '0);
  assign differs = (raw != filt);
  assign ripe    = (cnt >= lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (bypass) begin
      filt <= raw;
      cnt  <= '0;
    end else if (!differs) begin
      cnt  <= '0;
    end else if (ripe) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt  <= cnt + CW'(1);
    end
  end

  // R8: while the run of differing cycles is shorter than the limit, hold
  p_hold_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (({1'b0, cnt} + 1'b1) < {1'b0, lim})) |=> $stable(filt));

  // R7: without filtering the lane follows its input one cycle later
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (filt == $past(raw)));
endmodule

// File: rtl/serin8_frame.sv
module serin8_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_s,
  input  logic       sclk_s,
  input  logic       sdi_s,
  input  logic       wide,
  input  logic [7:0] data,
  input  logic [7:0] status,
  output logic       sdo,
  output logic       load_ev,
  output logic       rise_ev,
  output logic       fall_ev
);
  logic        cs_prev;
  logic        sclk_prev;
  logic        sdi_cap;
  logic        wide_q;
  logic [15:0] sr;

  assign load_ev = cs_prev & ~cs_n_s;
  assign rise_ev = ~cs_n_s & ~sclk_prev & sclk_s;
  assign fall_ev = ~cs_n_s & sclk_prev & ~sclk_s & ~load_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      sdi_cap   <= 1'b0;
      wide_q    <= 1'b0;
      sr        <= '0;
    end else begin
      cs_prev   <= cs_n_s;
      sclk_prev <= sclk_s;
      if (rise_ev) sdi_cap <= sdi_s;
      if (load_ev) begin
        wide_q <= wide;
        sr     <= wide ? {data, status} : {8'h00, data};
      end else if (fall_ev) begin
        sr <= {sr[14:0], sdi_cap};
      end
    end
  end

  assign sdo = cs_n_s ? 1'b0 : (wide_q ? sr[15] : sr[7]);

  // R1: the shift register moves only on a load or a serial clock fall
  p_shift_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ev || fall_ev) |=> $stable(sr));

  // R5: the first bit after the snapshot is the captured data MSB
  p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (cs_n_s || (sdo == $past(data[7]))));
endmodule

// File: rtl/serin8_crc_top.sv
module serin8_crc_top #(
  parameter int unsigned DB_SHORT = 25,
  parameter int unsigned DB_MED   = 750,
  parameter int unsigned DB_LONG  = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       sdi_i,
  input  logic [7:0] din_i,
  input  logic       wide_i,
  input  logic       ot_i,
  input  logic       uv_alarm_i,
  input  logic       uv_warn_i,
  input  logic [1:0] dbsel_i,
  output logic       sdo_o,
  output logic       fault_o
);
  import serin8_pkg::*;

  localparam int unsigned CW  = $clog2(DB_LONG + 1);
  localparam int unsigned LVW = DATA_W + 6;

  logic [2:0]        spi_s;
  logic [LVW-1:0]    lvl_s;
  logic              cs_n_s, sclk_s, sdi_s;
  logic [DATA_W-1:0] din_s, din_f;
  logic              wide_s, ot_s, uva_s, uvw_s;
  logic [1:0]        dbsel_s;
  logic [CW-1:0]     lim;
  logic              load_ev, rise_ev, fall_ev;

  serin8_sync #(.W(3), .RST_VAL(3'b100)) u_spi_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n_i, sclk_i, sdi_i}), .q(spi_s));

  serin8_sync #(.W(LVW), .RST_VAL('0)) u_lvl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({din_i, wide_i, ot_i, uv_alarm_i, uv_warn_i, dbsel_i}), .q(lvl_s));

  assign {cs_n_s, sclk_s, sdi_s} = spi_s;
  assign {din_s, wide_s, ot_s, uva_s, uvw_s, dbsel_s} = lvl_s;

  always_comb begin
    unique case (dbsel_s)
      2'b00:   lim = '0;
      2'b01:   lim = CW'(DB_SHORT);
      2'b10:   lim = CW'(DB_MED);
      default: lim = CW'(DB_LONG);
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    serin8_dbnc_lane #(.CW(CW)) u_lane (
      .clk(clk), .rst_n(rst_n), .raw(din_s[g]), .lim(lim), .filt(din_f[g]));
  end

  serin8_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .wide(wide_s), .data(din_f), .status(status_of(din_f, ot_s, uva_s, uvw_s)),
    .sdo(sdo_o), .load_ev(load_ev), .rise_ev(rise_ev), .fall_ev(fall_ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_o <= 1'b0;
    else        fault_o <= ot_s | uva_s;
  end

  // R9: fault follows the synchronized alarm flags one cycle later
  p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_o == $past(ot_s | uva_s)));

  // R1: a serial clock rise and fall never coincide with a snapshot
  p_edge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ev, rise_ev, fall_ev}));
endmodule

// File: tb/test_serin8_crc_top.sv
module test_serin8_crc_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [7:0] din = '0;
  logic wide = 1'b1, ot = 1'b0, uva = 1'b0, uvw = 1'b0;
  logic [1:0] dbsel = 2'b00;
  logic sdo, fault;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serin8_crc_top #(.DB_SHORT(4), .DB_MED(12), .DB_LONG(40)) i_serin8_crc_top (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .din_i(din), .wide_i(wide), .ot_i(ot), .uv_alarm_i(uva), .uv_warn_i(uvw),
    .dbsel_i(dbsel), .sdo_o(sdo), .fault_o(fault));

  // {wide, ot, uva, uvw, data}
  localparam logic [11:0] VEC [6] = '{
    {4'b1000, 8'hA5}, {4'b1100, 8'h3C}, {4'b1010, 8'hFF},
    {4'b1001, 8'h01}, {4'b0000, 8'h96}, {4'b0111, 8'h00}};
  localparam logic [23:0] PAT [6] = '{
    24'hC3_5A_E1, 24'h0F_F0_81, 24'hAA_55_3C, 24'h12_34_56, 24'hFE_01_7B,
    24'h99_66_0F};

  function automatic logic [4:0] crc_ref(input logic [7:0] d);
    logic [12:0] r = {d, 5'b0};
    for (int i = 12; i >= 5; i--)
      if (r[i]) r[i -: 6] = r[i -: 6] ^ 6'b110101;
    return r[4:0];
  endfunction

  function automatic logic [23:0] exp_frame(input logic w, input logic o,
      input logic a, input logic v, input logic [7:0] d, input logic [23:0] p);
    logic [7:0] st = {crc_ref(d), !a, o, !v};
    return w ? {d, st, p[23:16]} : {d, p[23:8]};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] pat, input bit chg,
                       output logic [23:0] rx);
    cs_n = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      sdi = pat[i];
      cyc(H);
      rx[i] = sdo;
      if (chg && i == 20) begin
        din = ~din; ot = ~ot; wide = ~wide; uva = ~uva;
      end
      sclk = 1'b1;
      cyc(H);
      sclk = 1'b0;
    end
    cyc(H);
    cs_n = 1'b1;
    cyc(2 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx;
    logic [7:0]  d0;
    cyc(3);
    check("R10 sdo in reset", {23'd0, sdo}, 24'd0);
    check("R10 fault in reset", {23'd0, fault}, 24'd0);
    rst_n = 1'b1;
    cyc(4);
    // R10: filtered byte is 0 right after reset
    frame(24'h000000, 1'b0, rx);
    check("R10 first frame", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 24'h0));

    // R1 R2 R3 R4 R7: table walk, no debounce
    for (int k = 0; k < 6; k++) begin
      {wide, ot, uva, uvw, din} = VEC[k];
      cyc(4);
      frame(PAT[k], 1'b0, rx);
      check("R1/R2/R3/R4/R7 vector", rx,
            exp_frame(VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0], PAT[k]));
    end

    // R6: idle output low
    cyc(5);
    check("R6 idle sdo", {23'd0, sdo}, 24'd0);

    // R9: fault output
    ot = 1'b1; uva = 1'b0; cyc(4);
    check("R9 fault on ot", {23'd0, fault}, 24'd1);
    ot = 1'b0; uva = 1'b1; cyc(4);
    check("R9 fault on alarm", {23'd0, fault}, 24'd1);
    uva = 1'b0; uvw = 1'b1; cyc(4);
    check("R9 no fault on warn", {23'd0, fault}, 24'd0);
    uvw = 1'b0;

    // R5: changes during a frame are ignored
    wide = 1'b1; ot = 1'b0; uva = 1'b0; din = 8'h4B;
    cyc(6);
    frame(24'h5E_A7_C1, 1'b1, rx);
    check("R5 mid-frame change", rx,
          exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h4B, 24'h5E_A7_C1));
    wide = 1'b1; ot = 1'b0; uva = 1'b0;

    // R8: short debounce (4 cycles)
    dbsel = 2'b01; din = 8'h3C; cyc(20);
    din = 8'h3D; cyc(2); din = 8'h3C; cyc(20);
    frame(24'h0, 1'b0, rx);
    check("R8 short glitch ignored", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 24'h0));
    din = 8'h81; cyc(12);
    frame(24'h0, 1'b0, rx);
    check("R8 short level accepted", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 24'h0));

    // R8: long debounce (40 cycles)
    dbsel = 2'b11; cyc(4); din = 8'h5A; cyc(15);
    frame(24'h0, 1'b0, rx);
    check("R8 long not yet", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 24'h0));
    cyc(60);
    frame(24'h0, 1'b0, rx);
    check("R8 long accepted", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 24'h0));

    // R8: medium debounce (12 cycles)
    dbsel = 2'b10; cyc(4);
    d0 = 8'hC7; din = d0; cyc(8); din = 8'h5A; cyc(30);
    frame(24'h0, 1'b0, rx);
    check("R8 medium glitch ignored", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 24'h0));
    din = d0; cyc(25);
    frame(24'h0, 1'b0, rx);
    check("R8 medium accepted", rx, exp_frame(1'b1, 1'b0, 1'b0, 1'b0, d0, 24'h0));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule